// File: doc/BRIEF.md
# Host I/O Window Memory Bridge

This block gives a host with only byte-wide I/O access a window into a 32-bit internal memory. The host sees eight byte registers: two mailbox bytes, two address bytes, and four data bytes. The low address byte also carries a two-bit transfer mode. The data bytes either reach memory one byte at a time, or they pass through a 32-bit staging register. In the staged modes, a read of a chosen data byte fetches memory into the staging register. A write of a chosen data byte pushes the staging register out to memory.

In the auto-incrementing word mode, the host streams a block with repeated four-byte passes over the data registers. The word address steps by one word after each pass. The memory side is a plain synchronous word port with byte enables and a one-cycle read latency. The two mailbox bytes let the host and the device exchange a byte each way. Each mailbox has a sticky flag that the reading side clears.

Top module: `iowin_bridge`

## Requirements
- R1: After reset, host_rdata, both mailbox flags, the mode field and the word address are zero, and mem_we and mem_re are low while no host strobe is present.
- R2: Offset 2 holds the mode in bits [1:0] and byte-address bits 7:2 in bits [7:2]. Offset 3 holds byte-address bits 14:8 in bits [6:0]; its bit 7 is dropped and reads back 0. Both registers read back their contents.
- R3: In mode 0 (byte), an access to offset 4+k (k = 0..3) reads or writes byte lane k of the current word directly. A write raises mem_we with mem_be equal to one-hot bit k. A read returns bits [8k+7:8k] of the memory word.
- R4: In mode 1 (16-bit), reading offset 4 loads staging lanes 0-1 from memory and reading offset 6 loads lanes 2-3; offsets 5 and 7 read staged lanes. Writes to any data offset update that staging lane. A write to offset 5 commits lanes 0-1 with mem_be 0011, and a write to offset 7 commits lanes 2-3 with mem_be 1100.
- R5: In modes 2 and 3 (word), reading offset 4 fetches the whole word into staging and returns lane 0. Reading offsets 5 to 7 returns staged lanes and issues no memory read.
- R6: In modes 2 and 3, writes to offsets 4 to 6 only update staging. A write to offset 7 writes all four staged lanes, with lane 3 taken from the written byte, using mem_be 1111.
- R7: In mode 3 only, any read or write of offset 7 advances the word address by one (4 bytes) once that access is done. Mode 2 never changes the address.
- R8: The word address wraps modulo the window size, so byte address 0x7FFC steps to 0x0000.
- R9: A host read strobe sampled at one rising edge updates host_rdata at the next rising edge; host_rdata holds its old value in between and until the next read.
- R10: A host write to offset 0 stores the byte for the device and sets dev_h2d_flag. dev_h2d_ack clears the flag, and a set in the same cycle wins.
- R11: A device write stores dev_d2h_wdata and sets host_d2h_flag. A host read of offset 1 returns the stored byte and clears the flag, and a set in the same cycle wins. Host writes to offset 1 have no effect.
- R12: mem_re and mem_we are asserted only in the cycle that a host read or write strobe addresses a data offset (4 to 7). mem_addr always shows the current word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rdata | output | 8 | Host read byte, registered |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after mem_re |
| dev_h2d_data | output | 8 | Host-to-device mailbox byte |
| dev_h2d_flag | output | 1 | Host-to-device mailbox full |
| dev_h2d_ack | input | 1 | Device read of host-to-device mailbox |
| dev_d2h_wdata | input | 8 | Device-to-host mailbox write byte |
| dev_d2h_wr | input | 1 | Device-to-host mailbox write strobe |
| host_d2h_flag | output | 1 | Device-to-host mailbox full |

## Verification
Memory requests appear in the same cycle as the host strobe. Mailbox flags, staging contents and address steps change at the edge that samples the strobe. Read data reaches host_rdata one edge after that. The bench changes strobes on falling edges and holds each one for a single cycle. It samples host_rdata, the flags and the write monitors at the falling edge after the second rising edge, so every result is already settled. One directed read also samples between the two edges to confirm the old value is still held.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    XF_BYTE = 2'd0,
    XF_HALF = 2'd1,
    XF_WORD = 2'd2,
    XF_WINC = 2'd3
  } xfer_mode_e;

  localparam logic [2:0] REG_H2D = 3'd0;
  localparam logic [2:0] REG_D2H = 3'd1;
  localparam logic [2:0] REG_ALO = 3'd2;
  localparam logic [2:0] REG_AHI = 3'd3;

  // byte enables used when a data-lane write reaches memory
  function automatic logic [LANES-1:0] commit_be(xfer_mode_e m, logic [1:0] lane);
    unique case (m)
      XF_BYTE: commit_be = 4'b0001 << lane;
      XF_HALF: commit_be = lane[1] ? 4'b1100 : 4'b0011;
      default: commit_be = 4'b1111;
    endcase
  endfunction

  function automatic logic lane_commits(xfer_mode_e m, logic [1:0] lane);
    unique case (m)
      XF_BYTE: lane_commits = 1'b1;
      XF_HALF: lane_commits = lane[0];
      default: lane_commits = (lane == 2'd3);
    endcase
  endfunction

  function automatic logic lane_fetches(xfer_mode_e m, logic [1:0] lane);
    unique case (m)
      XF_BYTE: lane_fetches = 1'b1;
      XF_HALF: lane_fetches = ~lane[0];
      default: lane_fetches = (lane == 2'd0);
    endcase
  endfunction

  // staging lanes refreshed by a fetch
  function automatic logic [LANES-1:0] fill_mask(xfer_mode_e m, logic [1:0] lane);
    unique case (m)
      XF_BYTE: fill_mask = 4'b0000;
      XF_HALF: fill_mask = (lane == 2'd0) ? 4'b0011 :
                           (lane == 2'd2) ? 4'b1100 : 4'b0000;
      default: fill_mask = (lane == 2'd0) ? 4'b1111 : 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/iowin_mbox.sv
module iowin_mbox #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set,
  input  logic [W-1:0] set_data,
  input  logic         clr,
  output logic [W-1:0] data,
  output logic         flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      flag <= 1'b0;
    end else begin
      if (set) begin
        data <= set_data;
        flag <= 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iowin_addr.sv
module iowin_addr
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int WA_W  = ADDR_W - 2,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [7:0]      wdata,
  input  logic            step,
  output xfer_mode_e      mode,
  output logic [WA_W-1:0] word_addr,
  output logic [7:0]      lo_byte,
  output logic [7:0]      hi_byte
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= XF_BYTE;
      word_addr <= '0;
    end else if (wr_lo) begin
      mode           <= xfer_mode_e'(wdata[1:0]);
      word_addr[5:0] <= wdata[7:2];
    end else if (wr_hi) begin
      word_addr[WA_W-1:6] <= wdata[HI_W-1:0];
    end else if (step) begin
      word_addr <= word_addr + WA_W'(1);
    end
  end

  assign lo_byte = {word_addr[5:0], mode};
  assign hi_byte = 8'(word_addr[WA_W-1:6]);

endmodule

// File: rtl/iowin_stage.sv
module iowin_stage
  import iowin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   wr_lane,
  input  logic [7:0]         wr_byte,
  input  logic [LANES-1:0]   fill_lane,
  input  logic [8*LANES-1:0] fill_word,
  output logic [8*LANES-1:0] word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        word[8*g +: 8] <= '0;
      end else if (wr_lane[g]) begin
        word[8*g +: 8] <= wr_byte;
      end else if (fill_lane[g]) begin
        word[8*g +: 8] <= fill_word[8*g +: 8];
      end
    end
  end

endmodule

// File: rtl/iowin_bridge.sv
module iowin_bridge
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         host_addr,
  input  logic [7:0]         host_wdata,
  input  logic               host_rd,
  input  logic               host_wr,
  output logic [7:0]         host_rdata,
  output logic [WA_W-1:0]    mem_addr,
  output logic               mem_re,
  output logic               mem_we,
  output logic [LANES-1:0]   mem_be,
  output logic [8*LANES-1:0] mem_wdata,
  input  logic [8*LANES-1:0] mem_rdata,
  output logic [7:0]         dev_h2d_data,
  output logic               dev_h2d_flag,
  input  logic               dev_h2d_ack,
  input  logic [7:0]         dev_d2h_wdata,
  input  logic               dev_d2h_wr,
  output logic               host_d2h_flag
);

  xfer_mode_e         cur_mode;
  logic [WA_W-1:0]    word_addr;
  logic [7:0]         lo_byte, hi_byte;
  logic [7:0]         d2h_data;
  logic [8*LANES-1:0] stage_word;

  logic               is_data;
  logic [1:0]         lane;
  logic               data_rd, data_wr, step;
  logic [LANES-1:0]   stage_wr;
  logic [LANES-1:0]   stage_fill;
  logic [7:0]         rd_val;

  // read return pipeline
  logic               rd_q, rd_mem_q;
  logic [1:0]         rd_lane_q;
  logic [LANES-1:0]   rd_fill_q;
  logic [7:0]         rd_val_q;

  assign is_data = host_addr[2];
  assign lane    = host_addr[1:0];
  assign data_rd = host_rd & is_data;
  assign data_wr = host_wr & is_data;
  assign step    = (host_rd | host_wr) & is_data & (lane == 2'd3) & (cur_mode == XF_WINC);

  iowin_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .wr_lo     (host_wr && host_addr == REG_ALO),
    .wr_hi     (host_wr && host_addr == REG_AHI),
    .wdata     (host_wdata),
    .step      (step),
    .mode      (cur_mode),
    .word_addr (word_addr),
    .lo_byte   (lo_byte),
    .hi_byte   (hi_byte)
  );

  iowin_mbox #(.W(8)) u_h2d (
    .clk      (clk),
    .rst      (rst),
    .set      (host_wr && host_addr == REG_H2D),
    .set_data (host_wdata),
    .clr      (dev_h2d_ack),
    .data     (dev_h2d_data),
    .flag     (dev_h2d_flag)
  );

  iowin_mbox #(.W(8)) u_d2h (
    .clk      (clk),
    .rst      (rst),
    .set      (dev_d2h_wr),
    .set_data (dev_d2h_wdata),
    .clr      (host_rd && host_addr == REG_D2H),
    .data     (d2h_data),
    .flag     (host_d2h_flag)
  );

  // staging lanes are written by the host only in staged modes
  assign stage_wr   = (data_wr && cur_mode != XF_BYTE) ? (4'b0001 << lane) : '0;
  assign stage_fill = rd_q ? rd_fill_q : '0;

  iowin_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr_lane   (stage_wr),
    .wr_byte   (host_wdata),
    .fill_lane (stage_fill),
    .fill_word (mem_rdata),
    .word      (stage_word)
  );

  // memory request, same cycle as the host strobe
  assign mem_addr = word_addr;
  assign mem_re   = data_rd & lane_fetches(cur_mode, lane);
  assign mem_we   = data_wr & lane_commits(cur_mode, lane);
  assign mem_be   = commit_be(cur_mode, lane);

  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    assign mem_wdata[8*g +: 8] = (cur_mode == XF_BYTE || lane == 2'(g)) ?
                                 host_wdata : stage_word[8*g +: 8];
  end

  always_comb begin
    unique case (host_addr)
      REG_H2D: rd_val = dev_h2d_data;
      REG_D2H: rd_val = d2h_data;
      REG_ALO: rd_val = lo_byte;
      REG_AHI: rd_val = hi_byte;
      default: rd_val = stage_word[8*lane +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= 1'b0;
      rd_mem_q   <= 1'b0;
      rd_lane_q  <= '0;
      rd_fill_q  <= '0;
      rd_val_q   <= '0;
      host_rdata <= '0;
    end else begin
      rd_q      <= host_rd;
      rd_mem_q  <= mem_re;
      rd_lane_q <= lane;
      rd_fill_q <= data_rd ? fill_mask(cur_mode, lane) : '0;
      rd_val_q  <= rd_val;
      if (rd_q) begin
        host_rdata <= rd_mem_q ? mem_rdata[8*rd_lane_q +: 8] : rd_val_q;
      end
    end
  end

endmodule

// File: rtl/iowin_bridge_chk.sv
module iowin_bridge_chk #(
  parameter int ADDR_W = 15,
  localparam int WA_W  = ADDR_W - 2
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      host_addr,
  input logic            host_rd,
  input logic            host_wr,
  input logic            mem_re,
  input logic            mem_we,
  input logic [3:0]      mem_be,
  input logic [WA_W-1:0] mem_addr,
  input logic            h2d_flag,
  input logic            d2h_flag,
  input logic            dev_d2h_wr,
  input logic [1:0]      cur_mode
);

  // R3
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                mem_be == 4'b1100 || mem_be == 4'b1111));

  // R12
  re_source_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (host_rd && host_addr[2]));

  // R12
  we_source_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (host_wr && host_addr[2]));

  // R7
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((host_wr || host_rd) && host_addr == 3'd7 && cur_mode == 2'd3)
      |=> (mem_addr == $past(mem_addr) + WA_W'(1)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(host_wr && (host_addr == 3'd2 || host_addr == 3'd3)) &&
     !((host_wr || host_rd) && host_addr == 3'd7))
      |=> $stable(mem_addr));

  // R10
  h2d_set_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd0) |=> h2d_flag);

  // R11
  d2h_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 3'd1 && !dev_d2h_wr) |=> !d2h_flag);

  // R11
  d2h_set_chk: assert property (@(posedge clk) disable iff (rst)
    dev_d2h_wr |=> d2h_flag);

endmodule

bind iowin_bridge iowin_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_be     (mem_be),
  .mem_addr   (mem_addr),
  .h2d_flag   (dev_h2d_flag),
  .d2h_flag   (host_d2h_flag),
  .dev_d2h_wr (dev_d2h_wr),
  .cur_mode   (cur_mode)
);

// File: tb/iowin_bridge_tb.sv
module iowin_bridge_tb;

  localparam int ADDR_W = 15;
  localparam int WA_W   = ADDR_W - 2;
  localparam int MWORDS = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst = 1'b1;
  logic [2:0]      host_addr = '0;
  logic [7:0]      host_wdata = '0;
  logic            host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]      host_rdata;
  logic [WA_W-1:0] mem_addr;
  logic            mem_re, mem_we;
  logic [3:0]      mem_be;
  logic [31:0]     mem_wdata;
  logic [31:0]     mem_rdata = '0;
  logic [7:0]      dev_h2d_data;
  logic            dev_h2d_flag;
  logic            dev_h2d_ack = 1'b0;
  logic [7:0]      dev_d2h_wdata = '0;
  logic            dev_d2h_wr = 1'b0;
  logic            host_d2h_flag;

  iowin_bridge #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_h2d_data(dev_h2d_data), .dev_h2d_flag(dev_h2d_flag),
    .dev_h2d_ack(dev_h2d_ack), .dev_d2h_wdata(dev_d2h_wdata),
    .dev_d2h_wr(dev_d2h_wr), .host_d2h_flag(host_d2h_flag)
  );

  // memory model (aliased to MWORDS words) and expected image
  logic [31:0] bmem   [MWORDS];
  logic [31:0] shadow [MWORDS];
  int          we_cnt = 0, re_cnt = 0;
  logic [3:0]  last_be = '0;

  always @(posedge clk) begin
    if (mem_we) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[mem_addr[9:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      we_cnt  <= we_cnt + 1;
      last_be <= mem_be;
    end
    if (mem_re) begin
      mem_rdata <= bmem[mem_addr[9:0]];
      re_cnt    <= re_cnt + 1;
    end
  end

  int nchk = 0, nfail = 0;

  // bench model state
  logic [1:0]      m_mode = 2'd0;
  logic [WA_W-1:0] m_wa = '0;
  logic [31:0]     m_st = '0;
  logic [7:0]      m_h2d = '0, m_d2h = '0;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checki(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_write(input logic [2:0] off, input logic [7:0] d);
    int k;
    k = int'(off[1:0]);
    if (off == 3'd0) m_h2d = d;
    else if (off == 3'd2) begin m_mode = d[1:0]; m_wa[5:0] = d[7:2]; end
    else if (off == 3'd3) m_wa[WA_W-1:6] = d[6:0];
    else if (off[2]) begin
      if (m_mode == 2'd0) shadow[m_wa[9:0]][8*k +: 8] = d;
      else begin
        m_st[8*k +: 8] = d;
        if (m_mode == 2'd1) begin
          if (k == 1) shadow[m_wa[9:0]][15:0]  = m_st[15:0];
          if (k == 3) shadow[m_wa[9:0]][31:16] = m_st[31:16];
        end else if (k == 3) begin
          shadow[m_wa[9:0]] = m_st;
          if (m_mode == 2'd3) m_wa = m_wa + WA_W'(1);
        end
      end
    end
  endtask

  task automatic m_read(input logic [2:0] off, output logic [7:0] e);
    int k;
    k = int'(off[1:0]);
    case (off)
      3'd0: e = m_h2d;
      3'd1: e = m_d2h;
      3'd2: e = {m_wa[5:0], m_mode};
      3'd3: e = {1'b0, m_wa[WA_W-1:6]};
      default: begin
        if (m_mode == 2'd0) e = shadow[m_wa[9:0]][8*k +: 8];
        else begin
          if (m_mode == 2'd1) begin
            if (k == 0) m_st[15:0]  = shadow[m_wa[9:0]][15:0];
            if (k == 2) m_st[31:16] = shadow[m_wa[9:0]][31:16];
          end else if (k == 0) m_st = shadow[m_wa[9:0]];
          e = m_st[8*k +: 8];
          if (m_mode == 2'd3 && k == 3) m_wa = m_wa + WA_W'(1);
        end
      end
    endcase
  endtask

  task automatic hwrite(input logic [2:0] off, input logic [7:0] d);
    m_write(off, d);
    @(negedge clk); host_addr = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] off, input string tag);
    logic [7:0] e;
    m_read(off, e);
    @(negedge clk); host_addr = off; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    @(negedge clk);
    check8(tag, host_rdata, e);
  endtask

  task automatic set_addr(input logic [14:0] a, input logic [1:0] mode);
    hwrite(3'd3, {1'b0, a[14:8]});
    hwrite(3'd2, {a[7:2], mode});
  endtask

  task automatic dev_write(input logic [7:0] d);
    @(negedge clk); dev_d2h_wdata = d; dev_d2h_wr = 1'b1;
    @(negedge clk); dev_d2h_wr = 1'b0;
    m_d2h = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    int w0, r0;
    logic [7:0] e;
    for (int i = 0; i < MWORDS; i++) begin
      bmem[i]   = 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
      shadow[i] = 32'(i) * 32'h9E37_79B1 + 32'h0123_4567;
    end
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check8("R1 host_rdata", host_rdata, 8'h00);
    checki("R1 h2d flag", int'(dev_h2d_flag), 0);
    checki("R1 d2h flag", int'(host_d2h_flag), 0);
    checki("R1 mem strobes", int'(mem_we | mem_re), 0);
    hread(3'd2, "R1 addr lo");
    hread(3'd3, "R1 addr hi");

    // R2 address registers
    hwrite(3'd2, 8'hA5);
    hread(3'd2, "R2 addr lo readback");
    hwrite(3'd3, 8'hFF);
    hread(3'd3, "R2 addr hi bit7 dropped");
    check8("R2 addr hi literal", host_rdata, 8'h7F);

    // R3 byte mode
    set_addr(15'h0010, 2'd0);
    w0 = we_cnt;
    hwrite(3'd5, 8'h5A);
    checki("R3 one write", we_cnt - w0, 1);
    checki("R3 be lane1", int'(last_be), 2);
    hread(3'd5, "R3 lane1 readback");
    hread(3'd4, "R3 lane0 untouched");
    hread(3'd7, "R3 lane3");

    // R4 halfword mode
    set_addr(15'h0020, 2'd1);
    w0 = we_cnt;
    hwrite(3'd4, 8'h11);
    checki("R4 lane0 stage only", we_cnt - w0, 0);
    hwrite(3'd5, 8'h22);
    checki("R4 low commit", we_cnt - w0, 1);
    checki("R4 be low", int'(last_be), 3);
    hwrite(3'd6, 8'h33);
    hwrite(3'd7, 8'h44);
    checki("R4 be high", int'(last_be), 12);
    hread(3'd6, "R4 upper fetch");
    hread(3'd7, "R4 upper staged");
    hread(3'd4, "R4 lower fetch");
    hread(3'd5, "R4 lower staged");

    // R5 word read
    set_addr(15'h0030, 2'd2);
    r0 = re_cnt;
    hread(3'd4, "R5 byte0 fetch");
    hread(3'd5, "R5 byte1");
    hread(3'd6, "R5 byte2");
    hread(3'd7, "R5 byte3");
    checki("R5 single fetch", re_cnt - r0, 1);

    // R6 word write
    w0 = we_cnt;
    hwrite(3'd4, 8'hC0);
    hwrite(3'd5, 8'hC1);
    hwrite(3'd6, 8'hC2);
    checki("R6 no commit yet", we_cnt - w0, 0);
    hwrite(3'd7, 8'hC3);
    checki("R6 commit", we_cnt - w0, 1);
    checki("R6 be all", int'(last_be), 15);
    hwrite(3'd2, 8'h30);
    for (int k = 4; k < 8; k++) hread(3'(k), "R6 byte readback");

    // R7 auto increment and mode 2 hold
    set_addr(15'h0040, 2'd3);
    for (int k = 4; k < 8; k++) hread(3'(k), "R7 stream read");
    hread(3'd2, "R7 advanced lo");
    check8("R7 advanced literal", host_rdata, 8'h47);
    for (int k = 4; k < 8; k++) hwrite(3'(k), 8'(8'h60 + k));
    hread(3'd2, "R7 advanced by write");
    set_addr(15'h0050, 2'd2);
    hread(3'd7, "R7 mode2 read");
    hread(3'd2, "R7 mode2 no step");
    check8("R7 mode2 literal", host_rdata, 8'h52);

    // R8 wrap
    set_addr(15'h7FFC, 2'd3);
    hread(3'd7, "R8 last word");
    hread(3'd2, "R8 wrapped lo");
    check8("R8 wrapped literal", host_rdata, 8'h03);
    hread(3'd3, "R8 wrapped hi");

    // R9 read timing
    hwrite(3'd2, 8'h84);
    hread(3'd3, "R9 setup");
    m_read(3'd2, e);
    @(negedge clk); host_addr = 3'd2; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    check8("R9 old value held", host_rdata, 8'h00);
    @(negedge clk);
    check8("R9 new value", host_rdata, e);

    // R12 register reads do not touch memory
    r0 = re_cnt; w0 = we_cnt;
    hread(3'd3, "R12 reg read");
    hwrite(3'd0, 8'h3C);
    checki("R12 no mem read", re_cnt - r0, 0);
    checki("R12 no mem write", we_cnt - w0, 0);

    // R10 host-to-device mailbox
    checki("R10 flag set", int'(dev_h2d_flag), 1);
    check8("R10 data", dev_h2d_data, 8'h3C);
    hread(3'd0, "R10 host readback");
    @(negedge clk); dev_h2d_ack = 1'b1;
    @(negedge clk); dev_h2d_ack = 1'b0;
    checki("R10 ack clears", int'(dev_h2d_flag), 0);
    @(negedge clk); host_addr = 3'd0; host_wdata = 8'h5E; host_wr = 1'b1; dev_h2d_ack = 1'b1;
    @(negedge clk); host_wr = 1'b0; dev_h2d_ack = 1'b0; m_h2d = 8'h5E;
    checki("R10 set wins", int'(dev_h2d_flag), 1);

    // R11 device-to-host mailbox
    dev_write(8'hC3);
    checki("R11 flag set", int'(host_d2h_flag), 1);
    hread(3'd1, "R11 read value");
    checki("R11 read clears", int'(host_d2h_flag), 0);
    hwrite(3'd1, 8'h77);
    hread(3'd1, "R11 host write ignored");
    checki("R11 flag after host write", int'(host_d2h_flag), 0);
    m_read(3'd1, e);
    @(negedge clk); host_addr = 3'd1; host_rd = 1'b1; dev_d2h_wdata = 8'h99; dev_d2h_wr = 1'b1;
    @(negedge clk); host_rd = 1'b0; dev_d2h_wr = 1'b0; m_d2h = 8'h99;
    @(negedge clk);
    check8("R11 old byte returned", host_rdata, e);
    checki("R11 set wins", int'(host_d2h_flag), 1);

    // random traffic over all modes (R3 R4 R5 R6 R7)
    for (int n = 0; n < 800; n++) begin
      int sel;
      sel = int'($urandom % 10);
      if (sel == 0) hwrite(3'd2, 8'($urandom));
      else if (sel == 1) hwrite(3'd3, 8'($urandom));
      else if (sel < 5) hwrite(3'(4 + ($urandom % 4)), 8'($urandom));
      else hread(3'(4 + ($urandom % 4)), "R3-mix random read");
    end
    hread(3'd2, "R7 random final lo");
    hread(3'd3, "R8 random final hi");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule